// File: doc/BRIEF.md
# Conditional Store and Flag Update Unit

This block sits next to an ALU and owns the four-bit status register. Each instruction supplies a four-bit condition code and a four-bit flag-select mask. The unit answers whether the instruction's result may be written back. It also folds the ALU's freshly produced flags into the status register, one flag at a time under the mask.

The write-back permission is combinational. It is taken from the condition code and from the status register as it stands, so it always reflects the flags from before the current instruction. The register loads on a clock edge when the update strobe is high. A synchronous active-high reset clears it.

The sixteen condition codes come in complementary pairs: bit 0 of the code selects the true or the inverted sense of one base predicate. The lower eight codes test single flags. The upper eight codes test unsigned and signed comparisons, plus an always/never pair.

Top module: `cond_flag_unit`

## Requirements
- R1: A synchronous reset, sampled high on a rising clock edge, clears the status register `flags_q` to 4'b0000 after that edge.
- R2: The status register bit order is Z at bit 0, N at bit 1, V at bit 2 and C at bit 3. Codes 4'h0 to 4'h7 make `store_ok` equal, in turn, to: !C, C, !V, V, !N, N, !Z, Z.
- R3: Code 4'h8 gives `store_ok` = !C && !Z (unsigned higher). Code 4'h9 gives C || Z (unsigned lower or same).
- R4: Code 4'hA gives `store_ok` = (N == V) (signed greater or equal). Code 4'hB gives (N != V) (signed less than).
- R5: Code 4'hC gives `store_ok` = !Z && (N == V) (signed greater than). Code 4'hD gives Z || (N != V) (signed less or equal).
- R6: Code 4'hE makes `store_ok` 1 and code 4'hF makes it 0, whatever the flags hold.
- R7: On an edge with `upd_en` high, each flag whose `flag_mask` bit is 1 takes the matching `alu_flags` bit. Each flag whose mask bit is 0 keeps its old value. The mask uses the same bit order as R2 (bit 0 Z, bit 1 N, bit 2 V, bit 3 C).
- R8: On an edge with `upd_en` low, `flags_q` keeps its value, whatever `alu_flags` and `flag_mask` hold.
- R9: In the cycle where an update is presented, `store_ok` is computed from the flags before that update. The updated flags govern `store_ok` from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the status register |
| upd_en | input | 1 | Load strobe for the status register |
| cond_code | input | 4 | Store condition selector |
| flag_mask | input | 4 | Per-flag update enable (bit 0 Z, 1 N, 2 V, 3 C) |
| alu_flags | input | 4 | Flags produced by the ALU this instruction, same bit order |
| store_ok | output | 1 | Result write-back permitted |
| flags_q | output | 4 | Current status register |

## Verification
The bench loads every one of the sixteen flag combinations and, for each one, evaluates all sixteen condition codes. This separates every predicate from its complement and from its neighbours, and exposes any swapped flag position. Single-bit masks are then applied on top of an all-clear register. A mixed mask is applied on top of an all-set register. Together these show which flag each mask bit controls and that unselected flags are kept. A cycle that carries an update while testing the very flag being changed shows whether the decision sees the old or the new flags. Strobe-low cycles with full masks and mid-run resets cover holding and clearing.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  localparam int FLAG_W = 4;
  localparam int CC_W   = 4;

  // Positions in the status register; neighbours decode these.
  localparam int FZ = 0;
  localparam int FN = 1;
  localparam int FV = 2;
  localparam int FC = 3;

  typedef logic [FLAG_W-1:0] flags_t;
  typedef logic [CC_W-1:0]   cc_t;

  // Base predicate groups selected by code bits [2:1] when bit 3 is set.
  typedef enum logic [1:0] {
    GRP_UNS_LS = 2'd0,
    GRP_SGN_LT = 2'd1,
    GRP_SGN_LE = 2'd2,
    GRP_NEVER  = 2'd3
  } cmp_grp_e;
endpackage

// File: rtl/cfu_cond_eval.sv
module cfu_cond_eval
  import cfu_pkg::*;
#(
  parameter int FW = FLAG_W,
  parameter int CW = CC_W
) (
  input  logic [FW-1:0] flags,
  input  logic [CW-1:0] code,
  output logic          pass
);
  localparam int SEL_W = CW - 2;

  logic z, n, v, c;
  logic sgn_mismatch;
  logic single_flag;
  logic compound;
  logic base;
  logic [SEL_W-1:0] sel;

  assign z = flags[FZ];
  assign n = flags[FN];
  assign v = flags[FV];
  assign c = flags[FC];
  assign sgn_mismatch = n ^ v;
  assign sel = code[CW-2:1];

  // Low half: pairs walk C, V, N, Z as the selector rises.
  always_comb begin
    unique case (sel)
      2'd0:    single_flag = c;
      2'd1:    single_flag = v;
      2'd2:    single_flag = n;
      default: single_flag = z;
    endcase
  end

  // High half: comparison predicates in their "true when bit0 set" sense.
  always_comb begin
    unique case (cmp_grp_e'(sel))
      GRP_UNS_LS: compound = c | z;
      GRP_SGN_LT: compound = sgn_mismatch;
      GRP_SGN_LE: compound = z | sgn_mismatch;
      default:    compound = 1'b0;
    endcase
  end

  assign base = code[CW-1] ? compound : single_flag;
  assign pass = code[0] ? base : ~base;
endmodule

// File: rtl/cfu_flag_merge.sv
module cfu_flag_merge
  import cfu_pkg::*;
#(
  parameter int FW = FLAG_W
) (
  input  logic [FW-1:0] cur,
  input  logic [FW-1:0] fresh,
  input  logic [FW-1:0] mask,
  output logic [FW-1:0] merged
);
  for (genvar i = 0; i < FW; i++) begin : g_bit
    assign merged[i] = mask[i] ? fresh[i] : cur[i];
  end
endmodule

// File: rtl/cfu_flag_reg.sv
module cfu_flag_reg
  import cfu_pkg::*;
#(
  parameter int FW = FLAG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [FW-1:0] d,
  output logic [FW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
  import cfu_pkg::*;
#(
  parameter int FW = FLAG_W,
  parameter int CW = CC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_en,
  input  logic [CW-1:0] cond_code,
  input  logic [FW-1:0] flag_mask,
  input  logic [FW-1:0] alu_flags,
  output logic          store_ok,
  output logic [FW-1:0] flags_q
);
  logic [FW-1:0] flags_nxt;

  // Decision uses the registered (pre-update) flags.
  cfu_cond_eval #(.FW(FW), .CW(CW)) u_eval (
    .flags (flags_q),
    .code  (cond_code),
    .pass  (store_ok)
  );

  cfu_flag_merge #(.FW(FW)) u_merge (
    .cur    (flags_q),
    .fresh  (alu_flags),
    .mask   (flag_mask),
    .merged (flags_nxt)
  );

  cfu_flag_reg #(.FW(FW)) u_reg (
    .clk  (clk),
    .rst  (rst),
    .load (upd_en),
    .d    (flags_nxt),
    .q    (flags_q)
  );
endmodule

// File: rtl/cond_flag_unit_chk.sv
module cond_flag_unit_chk
  import cfu_pkg::*;
#(
  parameter int FW = FLAG_W,
  parameter int CW = CC_W
) (
  input logic          clk,
  input logic          rst,
  input logic          upd_en,
  input logic [CW-1:0] cond_code,
  input logic [FW-1:0] flag_mask,
  input logic [FW-1:0] alu_flags,
  input logic          store_ok,
  input logic [FW-1:0] flags_q
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (flags_q == '0));

  assert_zset_code_R2: assert property (@(posedge clk) disable iff (rst)
    (cond_code == 4'h7) |-> (store_ok == flags_q[FZ]));

  assert_gt_code_R5: assert property (@(posedge clk) disable iff (rst)
    (cond_code == 4'hC) |-> (store_ok == (!flags_q[FZ] && (flags_q[FN] == flags_q[FV]))));

  assert_always_true_R6: assert property (@(posedge clk) disable iff (rst)
    (cond_code == 4'hE) |-> store_ok);

  assert_never_true_R6: assert property (@(posedge clk) disable iff (rst)
    (cond_code == 4'hF) |-> !store_ok);

  assert_masked_load_R7: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> ((flags_q & $past(flag_mask)) == ($past(alu_flags) & $past(flag_mask))));

  assert_masked_keep_R7: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (((flags_q ^ $past(flags_q)) & ~$past(flag_mask)) == '0));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(flags_q));
endmodule

bind cond_flag_unit cond_flag_unit_chk #(.FW(FW), .CW(CW)) u_chk (.*);

// File: tb/cond_flag_unit_tb.sv
module cond_flag_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       upd_en = 1'b0;
  logic [3:0] cond_code = 4'hE;
  logic [3:0] flag_mask = 4'h0;
  logic [3:0] alu_flags = 4'h0;
  logic       store_ok;
  logic [3:0] flags_q;

  always #5 clk = ~clk;

  cond_flag_unit u_dut (
    .clk(clk), .rst(rst), .upd_en(upd_en), .cond_code(cond_code),
    .flag_mask(flag_mask), .alu_flags(alu_flags),
    .store_ok(store_ok), .flags_q(flags_q)
  );

  typedef struct {
    logic       st;
    logic [3:0] fl;
    string      tag;
  } exp_t;

  exp_t sbq[$];
  int   nvec = 0;
  int   nbad = 0;
  logic [3:0] model = 4'h0;
  bit   done = 0;

  // Independent reference: z=bit0 n=bit1 v=bit2 c=bit3.
  function automatic logic ref_cond(input logic [3:0] cc, input logic [3:0] f);
    logic z, n, v, c;
    z = f[0]; n = f[1]; v = f[2]; c = f[3];
    case (cc)
      4'h0: return !c;
      4'h1: return c;
      4'h2: return !v;
      4'h3: return v;
      4'h4: return !n;
      4'h5: return n;
      4'h6: return !z;
      4'h7: return z;
      4'h8: return !c && !z;
      4'h9: return c || z;
      4'hA: return n == v;
      4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] cc);
    if (cc < 4'h8)       return "R2";
    else if (cc < 4'hA)  return "R3";
    else if (cc < 4'hC)  return "R4";
    else if (cc < 4'hE)  return "R5";
    else                 return "R6";
  endfunction

  task automatic apply(input logic [3:0] cc, input logic [3:0] m,
                       input logic [3:0] af, input logic up, input string tag);
    exp_t e;
    @(negedge clk);
    cond_code = cc; flag_mask = m; alu_flags = af; upd_en = up;
    e.st = ref_cond(cc, model);
    e.fl = model;
    e.tag = tag;
    sbq.push_back(e);
    if (up) model = (model & ~m) | (af & m);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; upd_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    model = 4'h0;
  endtask

  // Monitor: compares each queued expectation 2 ns after the driving edge.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (sbq.size() > 0) begin
        bit bad;
        e = sbq.pop_front();
        nvec++;
        bad = 0;
        if (store_ok !== e.st) begin
          $display("FAIL %s store_ok: actual %b expected %b (code %h flags %b)",
                   e.tag, store_ok, e.st, cond_code, e.fl);
          bad = 1;
        end
        if (flags_q !== e.fl) begin
          $display("FAIL %s flags_q: actual %b expected %b", e.tag, flags_q, e.fl);
          bad = 1;
        end
        if (bad) nbad++;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    apply(4'hE, 4'h0, 4'hF, 1'b0, "R1");

    // R2..R6: every flag value against every code
    for (int f = 0; f < 16; f++) begin
      apply(4'hE, 4'hF, f[3:0], 1'b1, "R7");
      for (int cc = 0; cc < 16; cc++)
        apply(cc[3:0], 4'hF, ~f[3:0], 1'b0, tag_of(cc[3:0]));
    end

    // R7: single-bit masks onto a clear register
    for (int b = 0; b < 4; b++) begin
      apply(4'hE, 4'hF, 4'h0, 1'b1, "R7");
      apply(4'hE, 4'h1 << b, 4'hF, 1'b1, "R7");
      apply(4'hE, 4'h0, 4'h0, 1'b0, "R7");
    end
    // R7: mixed mask onto an all-set register
    apply(4'hE, 4'hF, 4'hF, 1'b1, "R7");
    apply(4'hE, 4'h5, 4'h0, 1'b1, "R7");
    apply(4'hE, 4'h0, 4'h0, 1'b0, "R7");

    // R8: strobe low with full mask and differing ALU flags
    apply(4'hE, 4'hF, 4'h0, 1'b0, "R8");
    apply(4'hE, 4'hF, 4'h3, 1'b0, "R8");
    apply(4'hE, 4'h0, 4'h0, 1'b0, "R8");

    // R9: update of Z while testing Z set
    apply(4'hE, 4'hF, 4'h0, 1'b1, "R9");
    apply(4'h7, 4'h1, 4'h1, 1'b1, "R9");
    apply(4'h7, 4'h0, 4'h0, 1'b0, "R9");
    apply(4'hB, 4'h6, 4'h4, 1'b1, "R9");
    apply(4'hB, 4'h0, 4'h0, 1'b0, "R9");

    // R1: mid-run reset from a loaded register
    apply(4'hE, 4'hF, 4'hF, 1'b1, "R1");
    do_reset();
    apply(4'h0, 4'h0, 4'hF, 1'b0, "R1");

    @(negedge clk);
    #4;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule